// File: doc/BRIEF.md
# Edge-Triggered Up/Down Event Counter

This block keeps an eight-bit count that moves by one step for every event and shows the count on eight LED outputs. An event comes from one of two sources, picked by a mode input. The first source is a rising edge on a push-button line. The second is a slow internal tick of about 1.5 Hz, made by dividing the 50 MHz system clock.

A direction switch picks whether each event adds one or subtracts one. The count wraps modulo 256 at both ends. A second push-button clears the count on the clock edge.

Everything runs on the one system clock. The button line is never used as a clock. It passes through two registers, and the edge detector between them makes a pulse one clock wide that enables the counter. The divider also makes a pulse one clock wide, once per period. For simulation, a parameter shortens the divide ratio.

Top module: `evt_counter`

## Requirements
- R1: While `btn_clear` is 1 at a rising clock edge, `leds` reads 0 after that edge. This holds even when an event falls in the same cycle. The divider also restarts, so the next tick period begins from a known point.
- R2: When `dir_up` is 1 in the cycle an event is taken, the count rises by one. From 255 it wraps to 0.
- R3: When `dir_up` is 0 in the cycle an event is taken, the count falls by one. From 0 it wraps to 255.
- R4: When `auto_mode` is 0, each 0-to-1 change of `btn_step` is one event. Suppose `btn_step` is first seen high at clock edge k. Then `leds` changes after edge k+1. Holding the button high, and releasing it, give no further events.
- R5: When `auto_mode` is 0, the internal tick has no effect on `leds`.
- R6: When `auto_mode` is 1, one event is taken every `TICK_DIV` clock cycles. Let e be the last edge at which `btn_clear` was 1. The steps appear after edges e+TICK_DIV, e+2·TICK_DIV, and so on.
- R7: When `auto_mode` is 1, changes on `btn_step` have no effect on `leds`.
- R8: If `btn_step` is held high while `btn_clear` goes from 1 to 0 and stays high afterwards, no event is produced.
- R9: Between two clock edges, `leds` changes by at most one step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (50 MHz on the board) |
| btn_clear | input | 1 | Synchronous clear of the count, active high |
| btn_step | input | 1 | Step button; its rising edge is an event when `auto_mode` is 0 |
| dir_up | input | 1 | 1 = count up, 0 = count down |
| auto_mode | input | 1 | 0 = button events, 1 = internal tick events |
| leds | output | WIDTH | Current count |

## Verification
The clear and a counting event can fall in the same cycle. That event can be a tick that is due, or a button edge that is one clock old. The bench shortens the divider to five cycles so that ticks come often. Its random phase raises `btn_clear` on single cycles in the middle of button activity and mode changes, so clears land on cycles where a step would otherwise be taken. A cycle-by-cycle reference model decides each case from the requirements, and there the clear must win: the count reads zero and the tick phase restarts. A directed case also presses the button in the same cycle as the clear. It then holds the button through the release of the clear, which must not count.

// File: rtl/evt_counter.sv
module evt_counter #(
  parameter int WIDTH    = 8,
  parameter int TICK_DIV = 33333333
) (
  input  logic             clk,
  input  logic             btn_clear,
  input  logic             btn_step,
  input  logic             dir_up,
  input  logic             auto_mode,
  output logic [WIDTH-1:0] leds
);

  localparam int DIV_W = $clog2(TICK_DIV > 1 ? TICK_DIV : 2);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);

  logic [DIV_W-1:0] div_q;
  logic             tick;
  logic             btn_new, btn_old;
  logic             rise_pulse;
  logic             step_en;
  logic [WIDTH-1:0] count_q;

  assign tick = (div_q == DIV_LAST);

  always_ff @(posedge clk) begin
    if (btn_clear || tick) div_q <= '0;
    else                   div_q <= div_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (btn_clear) begin
      btn_new <= btn_step;
      btn_old <= btn_step;
    end else begin
      btn_new <= btn_step;
      btn_old <= btn_new;
    end
  end

  assign rise_pulse = btn_new & ~btn_old;
  assign step_en    = auto_mode ? tick : rise_pulse;

  always_ff @(posedge clk) begin
    if (btn_clear)    count_q <= '0;
    else if (step_en) count_q <= dir_up ? count_q + 1'b1 : count_q - 1'b1;
  end

  assign leds = count_q;

endmodule

// File: rtl/evt_counter_chk.sv
module evt_counter_chk #(
  parameter int WIDTH    = 8,
  parameter int TICK_DIV = 33333333
) (
  input logic             clk,
  input logic             btn_clear,
  input logic             dir_up,
  input logic             auto_mode,
  input logic             rise_pulse,
  input logic             tick,
  input logic [WIDTH-1:0] leds
);

  logic seen = 1'b0;
  always_ff @(posedge clk) if (btn_clear) seen <= 1'b1;

  // R1
  clear_zero_chk: assert property (@(posedge clk)
    btn_clear |=> (leds == '0));

  // R9
  single_step_chk: assert property (@(posedge clk) disable iff (btn_clear || !seen)
    !$past(btn_clear) |-> (leds == $past(leds) ||
                           leds == WIDTH'($past(leds) + 1'b1) ||
                           leds == WIDTH'($past(leds) - 1'b1)));

  // R2 R3
  dir_follow_chk: assert property (@(posedge clk) disable iff (btn_clear || !seen)
    (!$past(btn_clear) && leds != $past(leds)) |->
      (leds == ($past(dir_up) ? WIDTH'($past(leds) + 1'b1) : WIDTH'($past(leds) - 1'b1))));

  // R5 R7
  source_sel_chk: assert property (@(posedge clk) disable iff (btn_clear || !seen)
    (!$past(btn_clear) && leds != $past(leds)) |->
      ($past(auto_mode) ? $past(tick) : $past(rise_pulse)));

  generate
    if (TICK_DIV > 1) begin : g_tick
      // R6
      tick_pulse_chk: assert property (@(posedge clk) disable iff (btn_clear || !seen)
        tick |=> !tick);
    end
  endgenerate

endmodule

bind evt_counter evt_counter_chk #(.WIDTH(WIDTH), .TICK_DIV(TICK_DIV)) u_chk (
  .clk(clk), .btn_clear(btn_clear), .dir_up(dir_up), .auto_mode(auto_mode),
  .rise_pulse(rise_pulse), .tick(tick), .leds(leds)
);

// File: tb/evt_counter_tb.sv
`timescale 1ns/1ps
module evt_counter_tb;
  localparam int W = 8;
  localparam int D = 5;

  logic clk = 1'b0;
  logic btn_clear = 1'b1, btn_step = 1'b0, dir_up = 1'b1, auto_mode = 1'b0;
  logic [W-1:0] leds;

  int n_chk = 0, n_fail = 0;
  logic [W-1:0] m_cnt = '0;
  logic m_new = 1'b0, m_old = 1'b0;
  int m_div = 0;

  always #4 clk = ~clk;

  evt_counter #(.WIDTH(W), .TICK_DIV(D)) u_dut (
    .clk(clk), .btn_clear(btn_clear), .btn_step(btn_step),
    .dir_up(dir_up), .auto_mode(auto_mode), .leds(leds));

  function automatic logic [W-1:0] next_cnt(logic [W-1:0] c, logic ev, logic up);
    if (!ev) return c;
    return up ? W'(c + 1'b1) : W'(c - 1'b1);
  endfunction

  always @(posedge clk) begin
    logic ev;
    if (btn_clear) begin
      m_cnt = '0; m_div = 0; m_new = btn_step; m_old = btn_step;
    end else begin
      ev = auto_mode ? (m_div == D-1) : (m_new & ~m_old);
      m_cnt = next_cnt(m_cnt, ev, dir_up);
      m_div = (m_div == D-1) ? 0 : m_div + 1;
      m_old = m_new; m_new = btn_step;
    end
  end

  task automatic check(string tag, logic [W-1:0] exp);
    n_chk++;
    if (leds !== exp) begin
      n_fail++;
      $display("FAIL %s: leds=%0d expected=%0d at %0t", tag, leds, exp, $time);
    end
  endtask

  task automatic cyc(string tag, int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(tag, m_cnt);
    end
  endtask

  task automatic press(string tag);
    btn_step = 1'b1; cyc(tag, 3);
    btn_step = 1'b0; cyc(tag, 3);
  endtask

  task automatic clear(int n = 2);
    btn_clear = 1'b1; cyc("R1", n);
    btn_clear = 1'b0;
  endtask

  initial begin : watchdog
    #1000000;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [W-1:0] snap;
    void'($urandom(32'd4242));
    btn_clear = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", 8'd0);
    btn_clear = 1'b0;

    // R4 and R2: one press in button mode, counting up, gives exactly one step
    auto_mode = 1'b0; dir_up = 1'b1;
    cyc("R4", 2);
    press("R4");
    check("R4", 8'd1);
    btn_step = 1'b1; cyc("R4", 10); btn_step = 1'b0; cyc("R4", 4);
    check("R4", 8'd2);

    // R3: counting down wraps from 0 to 255
    dir_up = 1'b0;
    press("R3"); check("R3", 8'd1);
    press("R3"); check("R3", 8'd0);
    press("R3"); check("R3", 8'd255);

    // R2: counting up wraps from 255 to 0
    dir_up = 1'b1;
    press("R2"); check("R2", 8'd0);

    // R5: ticks run but are ignored in button mode
    cyc("R5", 4 * D);
    check("R5", 8'd0);

    // R6: the tick phase starts at the clear
    clear(2);
    auto_mode = 1'b1;
    for (int k = 1; k <= 3; k++) begin
      cyc("R6", D);
      check("R6", W'(k));
    end

    // R7: button activity is ignored in tick mode
    clear(2);
    for (int i = 0; i < 3 * D; i++) begin
      btn_step = ~btn_step;
      cyc("R7");
    end
    btn_step = 1'b0;
    check("R7", 8'd3);

    // R1: a clear wins over a button edge that lands in the same cycle
    auto_mode = 1'b0;
    btn_step = 1'b1; cyc("R1");
    btn_clear = 1'b1; cyc("R1");
    check("R1", 8'd0);

    // R8: the button is held through the release of the clear
    cyc("R8", 2);
    btn_clear = 1'b0;
    cyc("R8", 6);
    check("R8", 8'd0);
    btn_step = 1'b0;
    cyc("R8", 3);
    check("R8", 8'd0);

    // R9: random mix of modes, direction, button and single-cycle clears
    for (int i = 0; i < 4000; i++) begin
      if (($urandom % 3) == 0) btn_step = ~btn_step;
      if (($urandom % 50) == 0) dir_up = ~dir_up;
      if (($urandom % 80) == 0) auto_mode = ~auto_mode;
      btn_clear = (($urandom % 97) == 0);
      snap = leds;
      cyc("R9");
    end
    btn_clear = 1'b0;
    cyc("R9", 2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule